// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard tracker of an in-order-issue, out-of-order-completion pipeline. It serves five functional units: one integer unit (index 0), two multipliers (indices 1 and 2), one adder (index 3) and one divider (index 4). It sees one decoded instruction at a time (unit class, destination register and two source registers) and per-unit completion pulses. It answers with per-unit grants for issue, operand read and result write, and with a stall back to the fetch stage. The arithmetic, the register file and the data paths are outside the block. The units appear only as completion events.

Two tables hold the state. A status entry per unit records its destination, its sources, the unit that will produce each source, and a ready flag for each source. A result table per register names the unit that will write that register. Values are never forwarded and registers are never renamed. A write-after-write conflict holds the instruction at issue. A read-after-write conflict holds it at operand read. A write-after-read conflict holds the earlier instruction's result at write-back.

Top module: `sb_hazard_ctl`

## Requirements
- R1: Instructions are accepted strictly in arrival order, at most one per cycle. The class encoding is 0 = integer, 1 = multiply, 2 = add, 3 = divide. An accepted instruction raises exactly one bit of `issue_o`, the bit of the lowest-indexed idle unit of its class: integer 0, multiply 1 then 2, add 3, divide 4.
- R2: When no unit of the requested class is idle, `stall_o` is high, `issue_o` is zero, and the same instruction is retried. A unit freed by a write grant can accept a new instruction in the next cycle.
- R3: When the destination register still has a pending writer, the instruction stalls. It issues in the cycle after that writer's write grant.
- R4: `read_o[u]` rises once per instruction, no earlier than the cycle after issue, and only when neither source register has a pending writer. A source waiting on a producer becomes readable in the cycle after that producer's write grant.
- R5: A completion pulse counts only while its unit executes, meaning after its operand read. At any other time the pulse is ignored.
- R6: A completed unit requests its write grant in the cycle after its completion pulse.
- R7: A write grant is withheld while another unit holds a ready, unread source naming the same register. The grant follows in the cycle after that unit reads.
- R8: At most one write grant is given per cycle. Among the requesters, the lowest unit index wins.
- R9: A write grant frees the unit. It clears the register's pending writer and marks every source waiting on that unit as ready.
- R10: During and directly after reset every output is low and every unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_valid_i | input | 1 | Decoded instruction present |
| inst_class_i | input | 2 | Unit class of the instruction |
| inst_dst_i | input | REG_W | Destination register |
| inst_src1_i | input | REG_W | First source register |
| inst_src2_i | input | REG_W | Second source register |
| done_i | input | 5 | Per-unit execution-complete pulse |
| issue_o | output | 5 | Per-unit issue grant |
| read_o | output | 5 | Per-unit operand-read grant |
| wb_o | output | 5 | Per-unit result-write grant |
| stall_o | output | 1 | Hold the current instruction at fetch |

## Verification
Four properties are checked on every cycle:
- `issue_o` and the write grants are each at most one-hot.
- No write grant goes to a unit that did not request one.
- A blocked destination never issues.
- A unit reads once and is idle after its write.

The cycle-accurate relationships between events can only be shown by the bench's instruction sequences, because they depend on latencies and on the order of instructions. These are:
- a read one cycle after its producer writes;
- a write held back by an earlier reader until that reader has read;
- a structural stall that lasts until a unit frees;
- the tie-break when two completions land in the same cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = $clog2(NUM_FU);

  typedef enum logic [1:0] {CLS_INT = 2'd0, CLS_MUL = 2'd1, CLS_ADD = 2'd2, CLS_DIV = 2'd3} fu_class_e;
  typedef enum logic [1:0] {PH_IDLE, PH_OPS, PH_EXEC, PH_WB} phase_e;

  function automatic fu_class_e unit_class(input int idx);
    case (idx)
      0:       return CLS_INT;
      1, 2:    return CLS_MUL;
      3:       return CLS_ADD;
      default: return CLS_DIV;
    endcase
  endfunction
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl import sb_pkg::*; #(
  parameter int N_FU = NUM_FU
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      class_i,
  input  logic [N_FU-1:0] busy_i,
  input  logic            dst_pending_i,
  output logic [N_FU-1:0] issue_o,
  output logic            stall_o
);
  logic [N_FU-1:0] cand, pick;

  for (genvar u = 0; u < N_FU; u++) begin : g_cand
    assign cand[u] = !busy_i[u] && (unit_class(u) == fu_class_e'(class_i));
    if (u == 0) begin : g_first
      assign pick[u] = cand[u];
    end else begin : g_rest
      assign pick[u] = cand[u] && !(|cand[u-1:0]);
    end
  end

  assign stall_o = valid_i && ((cand == '0) || dst_pending_i);
  assign issue_o = (valid_i && !stall_o) ? pick : '0;

  AST_ISSUE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue_o)); // R1
  AST_NO_ISSUE_WAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dst_pending_i) |-> (issue_o == '0)); // R3
  AST_ISSUE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o & busy_i) == '0); // R2
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
  parameter int N_FU  = 5,
  parameter int REG_W = 5
) (
  input  logic [N_FU-1:0]  rj_i,
  input  logic [N_FU-1:0]  rk_i,
  input  logic [REG_W-1:0] fi_i [N_FU],
  input  logic [REG_W-1:0] fj_i [N_FU],
  input  logic [REG_W-1:0] fk_i [N_FU],
  output logic [N_FU-1:0]  block_o
);
  // a unit may not write while another still owes a read of that register
  always_comb begin
    block_o = '0;
    for (int u = 0; u < N_FU; u++) begin
      for (int v = 0; v < N_FU; v++) begin
        if (v != u && ((rj_i[v] && fj_i[v] == fi_i[u]) || (rk_i[v] && fk_i[v] == fi_i[u])))
          block_o[u] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb import sb_pkg::*; #(
  parameter int N_FU = NUM_FU,
  parameter int IW   = FU_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_FU-1:0] req_i,
  output logic [N_FU-1:0] grant_o,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  for (genvar u = 0; u < N_FU; u++) begin : g_pri
    if (u == 0) begin : g_first
      assign grant_o[u] = req_i[u];
    end else begin : g_rest
      assign grant_o[u] = req_i[u] && !(|req_i[u-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int u = 0; u < N_FU; u++)
      if (grant_o[u]) idx_o = IW'(u);
  end

  AST_WB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R8
  AST_WB_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0); // R8
endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl import sb_pkg::*; #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inst_valid_i,
  input  logic [1:0]        inst_class_i,
  input  logic [REG_W-1:0]  inst_dst_i,
  input  logic [REG_W-1:0]  inst_src1_i,
  input  logic [REG_W-1:0]  inst_src2_i,
  input  logic [NUM_FU-1:0] done_i,
  output logic [NUM_FU-1:0] issue_o,
  output logic [NUM_FU-1:0] read_o,
  output logic [NUM_FU-1:0] wb_o,
  output logic              stall_o
);
  // unit status table
  phase_e            phase_q [NUM_FU];
  logic [REG_W-1:0]  fi_q [NUM_FU];
  logic [REG_W-1:0]  fj_q [NUM_FU];
  logic [REG_W-1:0]  fk_q [NUM_FU];
  logic [FU_W-1:0]   qj_q [NUM_FU];
  logic [FU_W-1:0]   qk_q [NUM_FU];
  logic [NUM_FU-1:0] qj_v_q, qk_v_q, rj_q, rk_q;
  // register result table
  logic [NUM_REGS-1:0] rs_v_q;
  logic [FU_W-1:0]     rs_fu_q [NUM_REGS];

  logic [NUM_FU-1:0] busy, wb_req, war_block;
  logic [FU_W-1:0]   wb_idx, issue_idx;
  logic              wb_any, src1_pend, src2_pend;

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    assign busy[u]   = phase_q[u] != PH_IDLE;
    assign read_o[u] = (phase_q[u] == PH_OPS) && rj_q[u] && rk_q[u];
    assign wb_req[u] = (phase_q[u] == PH_WB) && !war_block[u];

    AST_READ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      read_o[u] |=> !read_o[u]); // R4
    AST_WB_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_o[u] |=> (phase_q[u] == PH_IDLE)); // R9
  end

  sb_issue_ctl #(.N_FU(NUM_FU)) u_issue (
    .clk_i, .rst_ni,
    .valid_i       (inst_valid_i),
    .class_i       (inst_class_i),
    .busy_i        (busy),
    .dst_pending_i (rs_v_q[inst_dst_i]),
    .issue_o       (issue_o),
    .stall_o       (stall_o)
  );

  sb_war_check #(.N_FU(NUM_FU), .REG_W(REG_W)) u_war (
    .rj_i (rj_q), .rk_i (rk_q),
    .fi_i (fi_q), .fj_i (fj_q), .fk_i (fk_q),
    .block_o (war_block)
  );

  sb_wb_arb #(.N_FU(NUM_FU), .IW(FU_W)) u_arb (
    .clk_i, .rst_ni,
    .req_i   (wb_req),
    .grant_o (wb_o),
    .idx_o   (wb_idx),
    .any_o   (wb_any)
  );

  always_comb begin
    issue_idx = '0;
    for (int u = 0; u < NUM_FU; u++)
      if (issue_o[u]) issue_idx = FU_W'(u);
  end

  // a producer writing in this very cycle no longer counts as pending
  assign src1_pend = rs_v_q[inst_src1_i] && !(wb_any && rs_fu_q[inst_src1_i] == wb_idx);
  assign src2_pend = rs_v_q[inst_src2_i] && !(wb_any && rs_fu_q[inst_src2_i] == wb_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < NUM_FU; u++) begin
        phase_q[u] <= PH_IDLE;
        fi_q[u] <= '0; fj_q[u] <= '0; fk_q[u] <= '0;
        qj_q[u] <= '0; qk_q[u] <= '0;
      end
      qj_v_q <= '0; qk_v_q <= '0; rj_q <= '0; rk_q <= '0;
      rs_v_q <= '0;
      for (int r = 0; r < NUM_REGS; r++) rs_fu_q[r] <= '0;
    end else begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (issue_o[u]) begin
          phase_q[u] <= PH_OPS;
          fi_q[u]    <= inst_dst_i;
          fj_q[u]    <= inst_src1_i;
          fk_q[u]    <= inst_src2_i;
          qj_q[u]    <= rs_fu_q[inst_src1_i];
          qk_q[u]    <= rs_fu_q[inst_src2_i];
          qj_v_q[u]  <= src1_pend;
          qk_v_q[u]  <= src2_pend;
          rj_q[u]    <= !src1_pend;
          rk_q[u]    <= !src2_pend;
        end else begin
          if (read_o[u]) begin
            phase_q[u] <= PH_EXEC;
            rj_q[u]    <= 1'b0;
            rk_q[u]    <= 1'b0;
          end else if (phase_q[u] == PH_EXEC && done_i[u]) begin
            phase_q[u] <= PH_WB;
          end else if (wb_o[u]) begin
            phase_q[u] <= PH_IDLE;
          end
          if (wb_any && qj_v_q[u] && qj_q[u] == wb_idx) begin
            qj_v_q[u] <= 1'b0;
            rj_q[u]   <= 1'b1;
          end
          if (wb_any && qk_v_q[u] && qk_q[u] == wb_idx) begin
            qk_v_q[u] <= 1'b0;
            rk_q[u]   <= 1'b1;
          end
        end
      end
      if (wb_any) rs_v_q[fi_q[wb_idx]] <= 1'b0;
      if (|issue_o) begin
        rs_v_q[inst_dst_i]  <= 1'b1;
        rs_fu_q[inst_dst_i] <= issue_idx;
      end
    end
  end

  AST_DONE_NEEDS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q[0] == PH_OPS && !read_o[0]) |=> (phase_q[0] != PH_WB)); // R5
endmodule

// File: tb/tb_sb_hazard_ctl.sv
`timescale 1ns/1ps
module tb_sb_hazard_ctl;
  localparam int NF = 5;
  localparam int RW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic inst_valid_i = 1'b0;
  logic [1:0] inst_class_i = '0;
  logic [RW-1:0] inst_dst_i = '0, inst_src1_i = '0, inst_src2_i = '0;
  logic [NF-1:0] done_i = '0, issue_o, read_o, wb_o;
  logic stall_o;

  always #10 clk_i = ~clk_i;

  sb_hazard_ctl #(.NUM_REGS(32)) dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int p_cls[64], p_dst[64], p_s1[64], p_s2[64];
  int p_len = 0, pc = 0;
  int m_unit[64], m_dst[64], m_s1[64], m_s2[64], m_stage[64], m_p1[64], m_p2[64];
  int n_ins = 0;
  int iss_c[64], rd_c[64], wb_c[64], dn_c[64];
  int lat[NF], cnt[NF];
  logic [NF-1:0] extra_done = '0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit rdy(input int p);
    return p < 0 || m_stage[p] == 3;
  endfunction

  function automatic int ucls(input int u);
    case (u)
      0: return 0;
      1, 2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit ubusy(input int u);
    for (int i = 0; i < n_ins; i++) if (m_stage[i] < 3 && m_unit[i] == u) return 1;
    return 0;
  endfunction

  function automatic int writer_of(input int r);
    for (int i = 0; i < n_ins; i++) if (m_stage[i] < 3 && m_dst[i] == r) return i;
    return -1;
  endfunction

  task automatic add_ins(input int c, input int d, input int a, input int b);
    p_cls[p_len] = c; p_dst[p_len] = d; p_s1[p_len] = a; p_s2[p_len] = b;
    p_len++;
  endtask

  task automatic step();
    logic [NF-1:0] dn, e_iss, e_rd, e_wb, req;
    bit e_stall;
    int pick;
    @(posedge clk_i); #1;
    cyc++;
    dn = extra_done;
    for (int u = 0; u < NF; u++) if (cnt[u] == 0) begin dn[u] = 1'b1; cnt[u] = -1; end
    done_i = dn;
    inst_valid_i = pc < p_len;
    if (pc < p_len) begin
      inst_class_i = 2'(p_cls[pc]); inst_dst_i = RW'(p_dst[pc]);
      inst_src1_i = RW'(p_s1[pc]);  inst_src2_i = RW'(p_s2[pc]);
    end
    @(negedge clk_i);
    e_iss = '0; e_stall = 1'b0; pick = -1;
    if (pc < p_len) begin
      for (int u = 0; u < NF; u++) if (pick < 0 && ucls(u) == p_cls[pc] && !ubusy(u)) pick = u;
      if (pick < 0 || writer_of(p_dst[pc]) >= 0) e_stall = 1'b1;
      else e_iss[pick] = 1'b1;
    end
    e_rd = '0; req = '0;
    for (int i = 0; i < n_ins; i++) begin
      if (m_stage[i] == 0 && rdy(m_p1[i]) && rdy(m_p2[i])) e_rd[m_unit[i]] = 1'b1;
      if (m_stage[i] == 2) begin
        bit war = 0;
        for (int j = 0; j < n_ins; j++)
          if (j != i && m_stage[j] == 0 &&
              ((m_s1[j] == m_dst[i] && rdy(m_p1[j])) || (m_s2[j] == m_dst[i] && rdy(m_p2[j]))))
            war = 1;
        if (!war) req[m_unit[i]] = 1'b1;
      end
    end
    e_wb = '0;
    for (int u = NF - 1; u >= 0; u--) if (req[u]) e_wb = NF'(1) << u;
    chk(issue_o == e_iss, "R1", "issue_o", int'(issue_o), int'(e_iss));
    chk(stall_o == e_stall, "R2", "stall_o", int'(stall_o), int'(e_stall));
    chk(read_o == e_rd, "R4", "read_o", int'(read_o), int'(e_rd));
    chk(wb_o == e_wb, "R6", "wb_o", int'(wb_o), int'(e_wb));
    for (int i = 0; i < n_ins; i++) begin
      if (m_stage[i] == 0 && read_o[m_unit[i]]) rd_c[i] = cyc;
      if (m_stage[i] == 2 && wb_o[m_unit[i]]) wb_c[i] = cyc;
    end
    for (int u = 0; u < NF; u++) if (cnt[u] > 0) cnt[u]--;
    for (int i = 0; i < n_ins; i++) begin
      if (m_stage[i] == 0 && e_rd[m_unit[i]]) begin
        m_stage[i] = 1; cnt[m_unit[i]] = lat[m_unit[i]];
      end else if (m_stage[i] == 1 && dn[m_unit[i]]) begin
        m_stage[i] = 2; dn_c[i] = cyc;
      end else if (m_stage[i] == 2 && e_wb[m_unit[i]]) begin
        m_stage[i] = 3;
      end
    end
    if (e_iss != '0) begin
      m_unit[n_ins] = pick; m_dst[n_ins] = p_dst[pc];
      m_s1[n_ins] = p_s1[pc]; m_s2[n_ins] = p_s2[pc];
      m_p1[n_ins] = writer_of(p_s1[pc]); m_p2[n_ins] = writer_of(p_s2[pc]);
      m_stage[n_ins] = 0; iss_c[n_ins] = cyc;
      rd_c[n_ins] = -1; wb_c[n_ins] = -1; dn_c[n_ins] = -1;
      n_ins++; pc++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    bit busy_any = 1;
    while ((pc < p_len || busy_any) && guard < 2000) begin
      step();
      guard++;
      busy_any = 0;
      for (int i = 0; i < n_ins; i++) if (m_stage[i] < 3) busy_any = 1;
    end
    repeat (2) step();
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int u = 0; u < NF; u++) cnt[u] = -1;
    lat[0] = 1; lat[1] = 8; lat[2] = 8; lat[3] = 1; lat[4] = 12;
    #35;
    chk(issue_o == 0 && read_o == 0 && wb_o == 0 && stall_o == 0, "R10", "outputs in reset",
        int'({issue_o, read_o, wb_o, stall_o}), 0);
    rst_ni = 1'b1;
    step();
    chk(issue_o == 0 && read_o == 0 && wb_o == 0 && stall_o == 0, "R10", "outputs after reset",
        int'({issue_o, read_o, wb_o, stall_o}), 0);
    // R5: completion pulses on idle units are ignored
    extra_done = '1;
    repeat (2) step();
    extra_done = '0;
    step();
    chk(wb_o == 0 && read_o == 0, "R5", "grants after stray done", int'({read_o, wb_o}), 0);

    // sequence A: load, load, multiply, subtract, divide, add
    add_ins(0, 6, 18, 19);  // 0
    add_ins(0, 2, 19, 18);  // 1
    add_ins(1, 0, 2, 4);    // 2
    add_ins(2, 8, 6, 2);    // 3
    add_ins(3, 10, 0, 6);   // 4
    add_ins(2, 6, 8, 2);    // 5
    drain();
    chk(rd_c[3] == wb_c[1] + 1, "R9", "sub read after load write", rd_c[3], wb_c[1] + 1);
    chk(rd_c[4] == wb_c[2] + 1, "R4", "div read after mul write", rd_c[4], wb_c[2] + 1);
    chk(wb_c[2] == dn_c[2] + 1, "R6", "mul write after done", wb_c[2], dn_c[2] + 1);
    chk(iss_c[5] == wb_c[3] + 1, "R2", "add issue after adder frees", iss_c[5], wb_c[3] + 1);
    chk(dn_c[5] < rd_c[4], "R7", "add done before div read", dn_c[5], rd_c[4]);
    chk(wb_c[5] == rd_c[4] + 1, "R7", "add write after div read", wb_c[5], rd_c[4] + 1);

    // sequence B: WAW stall and structural stall on the multipliers
    add_ins(1, 4, 1, 2);    // 6
    add_ins(2, 4, 3, 5);    // 7
    add_ins(1, 7, 1, 2);    // 8
    add_ins(1, 9, 1, 2);    // 9
    add_ins(1, 11, 1, 2);   // 10
    drain();
    chk(iss_c[7] == wb_c[6] + 1, "R3", "waw issue after writer", iss_c[7], wb_c[6] + 1);
    chk(m_unit[8] == 1 && m_unit[9] == 2, "R1", "multiplier selection", m_unit[9], 2);
    chk(iss_c[10] == wb_c[8] + 1, "R2", "third multiply after free", iss_c[10], wb_c[8] + 1);

    // sequence C: two completions in one cycle
    lat[0] = 2; lat[3] = 1;
    add_ins(0, 20, 18, 19); // 11
    add_ins(2, 21, 22, 23); // 12
    drain();
    chk(dn_c[11] == dn_c[12], "R8", "simultaneous done", dn_c[12], dn_c[11]);
    chk(wb_c[11] == dn_c[11] + 1, "R8", "unit 0 wins", wb_c[11], dn_c[11] + 1);
    chk(wb_c[12] == wb_c[11] + 1, "R8", "unit 3 follows", wb_c[12], wb_c[11] + 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule